// File: doc/BRIEF.md
# Double-Buffered Tile Configuration Registers

This block holds the configuration words of one array tile. A configuration master presents a 32-bit address and 32-bit data with a write or read strobe. The low part of the address names the tile. The block acts only when that part equals the tile's own identifier input. The upper address bits pick a feature and a register within it.

Every word exists twice, in a primary bank and in a shadow bank. A target-select input steers writes and read-back to one bank. A separate live-select input chooses which bank drives the routing-select outputs. A new route can therefore be loaded into the idle bank while the current one keeps running. Changing the live-select level then swaps every select word in the same cycle.

Top module: `cfg_dbuf_regs`

## Requirements
- R1: After reset, every word of both banks is zero, `route_sel_o` is all zeros and `rd_data_o` is zero.
- R2: The address splits into three fields: tile field in bits 15:0, feature index in bits 23:16, register index in bits 31:24. The word's slot is feature*NUM_REG + register, and it appears on `route_sel_o[slot*32 +: 32]`.
- R3: A write whose tile field differs from `tile_id_i` changes no word in either bank.
- R4: With `cfg_wr_i` low, no word changes, whatever the address and data are.
- R5: A write with feature index >= NUM_FEAT or register index >= NUM_REG changes no word.
- R6: A matching write with `cfg_target_i`=0 stores into the primary bank only. With `cfg_target_i`=1 it stores into the shadow bank only.
- R7: A read strobe loads `rd_data_o` at the next clock edge with the addressed word of the bank chosen by `cfg_target_i`. Without a read strobe, `rd_data_o` holds its value.
- R8: A read whose tile field mismatches, or whose indices are out of range, loads zero into `rd_data_o`.
- R9: `route_sel_o` shows the primary bank while `use_shadow_i` is 0 and the shadow bank while it is 1. The switch happens in the same cycle, without waiting for a clock edge.
- R10: A stored word appears on `route_sel_o` right after the clock edge that stores it, if its bank is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tile_id_i | input | 16 | Identifier of this tile |
| cfg_addr_i | input | 32 | Configuration address (tile, feature, register fields) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_target_i | input | 1 | Bank for writes and reads: 0 primary, 1 shadow |
| use_shadow_i | input | 1 | Bank driving the routing outputs: 0 primary, 1 shadow |
| rd_data_o | output | 32 | Registered read-back data |
| route_sel_o | output | NUM_FEAT*NUM_REG*32 | Live routing-select words, slot 0 in the low bits |

## Verification
The hardest case to reach is a state where the two banks hold different values at the same slot. Only then does a wrong bank selection show on the outputs. The stimulus first programs the primary bank, raises the target select and writes different data to the same addresses. It then reads both banks back and flips the live select between clock edges. Writes that must be dropped are aimed at slots already holding known data: mismatched tile, strobe low, and feature or register index just past the limit. A dropped write must not overwrite those slots or alias into slot 0.

// File: rtl/cfg_dbuf_pkg.sv
package cfg_dbuf_pkg;
  localparam int unsigned CFG_AW  = 32;
  localparam int unsigned CFG_DW  = 32;
  localparam int unsigned TILE_W  = 16;
  localparam int unsigned FEAT_W  = 8;
  localparam int unsigned REGI_W  = 8;

  // field order fixed by the address layout: register | feature | tile
  typedef struct packed {
    logic [REGI_W-1:0] reg_idx;
    logic [FEAT_W-1:0] feat_idx;
    logic [TILE_W-1:0] tile;
  } cfg_addr_t;

  typedef enum logic {
    BANK_PRI = 1'b0,
    BANK_SHD = 1'b1
  } bank_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_dbuf_pkg::*;
#(
  parameter int unsigned NUM_FEAT = 4,
  parameter int unsigned NUM_REG  = 2,
  parameter int unsigned SLOT_W   = 3
) (
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [TILE_W-1:0] tile_id_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  cfg_addr_t   fld;
  logic        tile_ok;
  logic        range_ok;
  logic [15:0] slot_full;

  always_comb begin
    fld       = cfg_addr_t'(addr_i);
    tile_ok   = (fld.tile == tile_id_i);
    range_ok  = (32'(fld.feat_idx) < NUM_FEAT) && (32'(fld.reg_idx) < NUM_REG);
    slot_full = 16'(fld.feat_idx) * 16'(NUM_REG) + 16'(fld.reg_idx);
    hit_o     = tile_ok && range_ok;
    slot_o    = slot_full[SLOT_W-1:0];
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SLOT = 8,
  parameter int unsigned SLOT_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_SLOT*DATA_W-1:0] words_o
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '0;
      else if (we_i && (slot_i == SLOT_W'(s)))       word_q <= wdata_i;
    end
    assign words_o[s*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SLOT = 8,
  parameter int unsigned SLOT_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic                       hit_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic                       sel_i,
  input  logic [NUM_SLOT*DATA_W-1:0] pri_i,
  input  logic [NUM_SLOT*DATA_W-1:0] shd_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [NUM_SLOT*DATA_W-1:0] src;
  logic [DATA_W-1:0]          word;

  always_comb begin
    src  = sel_i ? shd_i : pri_i;
    word = hit_i ? src[slot_i*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end
endmodule

// File: rtl/cfg_route_mux.sv
module cfg_route_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SLOT = 8
) (
  input  logic                       sel_i,
  input  logic [NUM_SLOT*DATA_W-1:0] pri_i,
  input  logic [NUM_SLOT*DATA_W-1:0] shd_i,
  output logic [NUM_SLOT*DATA_W-1:0] sel_o
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_word
    assign sel_o[s*DATA_W +: DATA_W] = sel_i ? shd_i[s*DATA_W +: DATA_W]
                                             : pri_i[s*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cfg_dbuf_regs.sv
module cfg_dbuf_regs
  import cfg_dbuf_pkg::*;
#(
  parameter int unsigned NUM_FEAT = 4,
  parameter int unsigned NUM_REG  = 2,
  localparam int unsigned NUM_SLOT = NUM_FEAT * NUM_REG,
  localparam int unsigned SLOT_W   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int unsigned ROUTE_W  = NUM_SLOT * CFG_DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TILE_W-1:0]  tile_id_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               cfg_wr_i,
  input  logic               cfg_rd_i,
  input  logic               cfg_target_i,
  input  logic               use_shadow_i,
  output logic [CFG_DW-1:0]  rd_data_o,
  output logic [ROUTE_W-1:0] route_sel_o
);
  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [ROUTE_W-1:0] bank_q [2];

  cfg_addr_dec #(
    .NUM_FEAT(NUM_FEAT), .NUM_REG(NUM_REG), .SLOT_W(SLOT_W)
  ) u_dec (
    .addr_i(cfg_addr_i), .tile_id_i(tile_id_i), .hit_o(hit), .slot_o(slot)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic we;
    assign we = cfg_wr_i && hit && (cfg_target_i == bank_e'(b));
    cfg_bank #(
      .DATA_W(CFG_DW), .NUM_SLOT(NUM_SLOT), .SLOT_W(SLOT_W)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .slot_i(slot),
      .wdata_i(cfg_wdata_i), .words_o(bank_q[b])
    );
  end

  cfg_rd_port #(
    .DATA_W(CFG_DW), .NUM_SLOT(NUM_SLOT), .SLOT_W(SLOT_W)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(cfg_rd_i), .hit_i(hit),
    .slot_i(slot), .sel_i(cfg_target_i), .pri_i(bank_q[0]),
    .shd_i(bank_q[1]), .rdata_o(rd_data_o)
  );

  cfg_route_mux #(
    .DATA_W(CFG_DW), .NUM_SLOT(NUM_SLOT)
  ) u_mux (
    .sel_i(use_shadow_i), .pri_i(bank_q[0]), .shd_i(bank_q[1]),
    .sel_o(route_sel_o)
  );
endmodule

// File: rtl/cfg_dbuf_regs_chk.sv
module cfg_dbuf_regs_chk #(
  parameter int unsigned ROUTE_W = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [15:0]        tile_id_i,
  input logic [31:0]        cfg_addr_i,
  input logic               cfg_wr_i,
  input logic               cfg_rd_i,
  input logic               cfg_target_i,
  input logic [31:0]        rd_data_o,
  input logic [ROUTE_W-1:0] pri_q,
  input logic [ROUTE_W-1:0] shd_q
);
  a_r4_no_strobe_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> ($stable(pri_q) && $stable(shd_q)));

  a_r3_tile_miss_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i[15:0] != tile_id_i) |=> ($stable(pri_q) && $stable(shd_q)));

  a_r6_shadow_keeps_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_target_i |=> $stable(pri_q));

  a_r6_primary_keeps_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_target_i |=> $stable(shd_q));

  a_r7_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rd_i |=> $stable(rd_data_o));

  a_r8_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && (cfg_addr_i[15:0] != tile_id_i)) |=> (rd_data_o == '0));
endmodule

bind cfg_dbuf_regs cfg_dbuf_regs_chk #(.ROUTE_W(ROUTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tile_id_i(tile_id_i),
  .cfg_addr_i(cfg_addr_i), .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i),
  .cfg_target_i(cfg_target_i), .rd_data_o(rd_data_o),
  .pri_q(bank_q[0]), .shd_q(bank_q[1])
);

// File: tb/cfg_dbuf_regs_tb.sv
module cfg_dbuf_regs_tb;
  localparam int CLK_P    = 10;
  localparam int NF       = 4;
  localparam int NR       = 2;
  localparam int NS       = NF * NR;
  localparam int RW       = NS * 32;
  localparam logic [15:0] TID = 16'h3A5C;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [15:0]   tile_id = TID;
  logic [31:0]   addr = '0, wdata = '0;
  logic          wr = 0, rd = 0, tgt = 0, use_shd = 0;
  logic [31:0]   rdata;
  logic [RW-1:0] route;

  int checks = 0, fails = 0;
  logic [31:0] pri_m [NS];
  logic [31:0] shd_m [NS];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  cfg_dbuf_regs #(.NUM_FEAT(NF), .NUM_REG(NR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tile_id_i(tile_id), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_target_i(tgt),
    .use_shadow_i(use_shd), .rd_data_o(rdata), .route_sel_o(route)
  );

  function automatic logic [31:0] mk_addr(int f, int r, logic [15:0] t);
    return {8'(r), 8'(f), t};
  endfunction

  function automatic bit hit_of(logic [31:0] a);
    return (a[15:0] == TID) && (int'(a[23:16]) < NF) && (int'(a[31:24]) < NR);
  endfunction

  function automatic int slot_of(logic [31:0] a);
    return int'(a[23:16]) * NR + int'(a[31:24]);
  endfunction

  task automatic chk32(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_route(string tag);
    logic [RW-1:0] exp;
    for (int s = 0; s < NS; s++) exp[s*32 +: 32] = use_shd ? shd_m[s] : pri_m[s];
    checks++;
    if (route !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, route, exp);
    end
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d, logic w, logic t);
    @(negedge clk);
    addr = a; wdata = d; wr = w; tgt = t;
    @(negedge clk);
    wr = 0;
    if (w && hit_of(a)) begin
      if (t) shd_m[slot_of(a)] = d;
      else   pri_m[slot_of(a)] = d;
    end
  endtask

  task automatic do_read(logic [31:0] a, logic t, string tag);
    @(negedge clk);
    addr = a; rd = 1; tgt = t;
    exp_q.push_back(hit_of(a) ? (t ? shd_m[slot_of(a)] : pri_m[slot_of(a)]) : 32'h0);
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 0;
  endtask

  // monitor: result of a read appears after the sampling edge
  initial forever begin
    @(posedge clk);
    if (rd === 1'b1) begin
      #(CLK_P/4);
      chk32(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin pri_m[s] = '0; shd_m[s] = '0; end
    #(CLK_P*2 + 1);
    chk32(rdata, 32'h0, "R1 rdata at reset");
    chk_route("R1 route at reset");
    @(negedge clk); rst_n = 1;

    // R2, R10: field layout and immediate visibility
    do_write(mk_addr(1, 1, TID), 32'hCAFE_0011, 1, 0);
    chk_route("R2 R10 slot 3 primary");
    do_read(mk_addr(1, 1, TID), 0, "R7 readback primary");
    do_write(mk_addr(3, 0, TID), 32'h1234_5678, 1, 0);
    do_write(mk_addr(0, 0, TID), 32'hA0A0_0000, 1, 0);
    chk_route("R2 slots 6 and 0");

    // R4: strobe low
    do_write(mk_addr(1, 1, TID), 32'hDEAD_BEEF, 0, 0);
    chk_route("R4 strobe low route");
    do_read(mk_addr(1, 1, TID), 0, "R4 strobe low readback");

    // R3: tile mismatch
    do_write(mk_addr(1, 1, TID ^ 16'h0001), 32'h5555_5555, 1, 0);
    chk_route("R3 tile miss route");
    do_read(mk_addr(1, 1, TID ^ 16'h8000), 0, "R8 tile miss read zero");
    do_read(mk_addr(1, 1, TID), 0, "R3 tile miss readback");

    // R5: out-of-range indices
    do_write(mk_addr(NF, 0, TID), 32'h7777_0001, 1, 0);
    do_write(mk_addr(0, NR, TID), 32'h7777_0002, 1, 0);
    chk_route("R5 out of range route");
    do_read(mk_addr(NF, 0, TID), 0, "R8 range miss read zero");
    do_read(mk_addr(0, 0, TID), 0, "R5 slot 0 untouched");

    // R6: shadow writes leave primary live
    do_write(mk_addr(1, 1, TID), 32'h5EAD_0011, 1, 1);
    do_write(mk_addr(2, 1, TID), 32'h5EAD_0021, 1, 1);
    chk_route("R6 primary unchanged by shadow write");
    do_read(mk_addr(1, 1, TID), 1, "R7 shadow readback");
    do_read(mk_addr(1, 1, TID), 0, "R6 primary readback");

    // R7: hold without read strobe
    do_write(mk_addr(2, 1, TID), 32'h0BAD_0BAD, 0, 1);
    chk32(rdata, pri_m[3], "R7 rdata holds");

    // R9: switch live bank between edges
    @(posedge clk); #(CLK_P/4);
    use_shd = 1; #1;
    chk_route("R9 shadow live same cycle");
    do_write(mk_addr(3, 1, TID), 32'hFACE_0031, 1, 1);
    chk_route("R10 shadow write visible");
    #(CLK_P/4); use_shd = 0; #1;
    chk_route("R9 back to primary");

    // sweep of all slots in both banks
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin
        do_write(mk_addr(f, r, TID), 32'h1000_0000 | (f << 8) | r, 1, 0);
        do_write(mk_addr(f, r, TID), 32'h2000_0000 | (f << 8) | r, 1, 1);
      end
    chk_route("R6 sweep primary");
    use_shd = 1; #1;
    chk_route("R9 sweep shadow");
    use_shd = 0;
    do_read(mk_addr(NF-1, NR-1, TID), 1, "R7 last slot shadow");
    do_read(mk_addr(NF-1, NR-1, TID), 0, "R7 last slot primary");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule